// File: doc/BRIEF.md
# Four-Bit Opcode ALU with Status Flags

This block is a purely combinational four-bit arithmetic and logic unit for two's complement operands in the range -8 to +7. A three-bit opcode picks one of eight functions: two arithmetic operations, four bitwise operations and two comparisons. The block drives a four-bit result and three status flags: carry, overflow and zero.

All arithmetic goes through one adder/subtractor, built as a chain of full-adder cells. The signed less-than test and the equality test both reuse this subtractor. Less-than is the sign of the difference XOR the subtraction overflow. Equality is the zero test of the difference. A comparison places its answer in result bit 0 and clears the upper three bits.

The block has no clock and no state. The result and flags follow the inputs directly.

Top module: `alu4_core`

## Requirements
- R1: With opcode 3'b000, the result is (A + B) modulo 16.
- R2: With opcode 3'b001, the result is (A - B) modulo 16.
- R3: With opcode 3'b000, carry is bit 4 of the unsigned sum of A and B. Overflow is 1 exactly when the true signed sum lies outside -8..7.
- R4: With opcode 3'b001, carry is the carry out of A + ~B + 1. This equals 1 exactly when unsigned A >= unsigned B. Overflow is 1 exactly when the true signed difference lies outside -8..7, and this includes B = -8.
- R5: With opcode 3'b010, the result is the bitwise inverse of A. B has no effect.
- R6: Opcode 3'b011 gives A AND B, 3'b100 gives A OR B, and 3'b101 gives A XOR B, each bitwise.
- R7: With opcode 3'b110, the result is 4'b0001 when A < B as signed numbers, and 4'b0000 otherwise.
- R8: With opcode 3'b111, the result is 4'b0001 when A equals B, and 4'b0000 otherwise.
- R9: For opcodes 3'b010 through 3'b111, carry and overflow are both 0.
- R10: For every opcode, zero is 1 exactly when the four-bit result is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Function select (encoding in R1-R8 tags above) |
| opnd_a | input | 4 | Operand A, two's complement |
| opnd_b | input | 4 | Operand B, two's complement |
| alu_res | output | 4 | Function result |
| flag_c | output | 1 | Carry out of the adder for add/subtract, else 0 |
| flag_v | output | 1 | Signed overflow for add/subtract, else 0 |
| flag_z | output | 1 | Result is all zeros |

## Verification
The checker assumes that the opcode and both operands are fully driven with known 0/1 values. It also assumes that it looks at the outputs only after the combinational path has settled from one input change. The bench applies each opcode and operand triple at a clock edge and holds it stable for a whole period. It reads the outputs half a period later. The stimulus covers all 2048 combinations of opcode and operand pair, so every corner is reached, including the most negative subtrahend and equal operands.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_NOTA = 3'b010,
    OP_AND  = 3'b011,
    OP_OR   = 3'b100,
    OP_XOR  = 3'b101,
    OP_SLT  = 3'b110,
    OP_EQ   = 3'b111
  } alu_op_e;

  // sum bit of one full-adder cell
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  // carry out of one full-adder cell
  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (ci & (x ^ y));
  endfunction

  // true when the opcode uses the subtracting form of the adder
  function automatic logic needs_sub(input logic [2:0] op);
    return (op == OP_SUB) || (op == OP_SLT) || (op == OP_EQ);
  endfunction

  // true when carry/overflow carry meaning
  function automatic logic is_arith(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/alu4_fa_cell.sv
module alu4_fa_cell
  import alu4_pkg::*;
(
  input  logic bit_x,
  input  logic bit_y,
  input  logic bit_ci,
  output logic bit_s,
  output logic bit_co
);
  always_comb begin
    bit_s  = fa_sum(bit_x, bit_y, bit_ci);
    bit_co = fa_carry(bit_x, bit_y, bit_ci);
  end
endmodule

// File: rtl/alu4_addsub.sv
module alu4_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         ovf
);
  localparam int CHAIN = W + 1;

  logic [W-1:0]     y_eff;
  logic [CHAIN-1:0] chain;

  // the subtrahend is inverted before the +1 comes in on the chain
  assign y_eff    = in_y ^ {W{do_sub}};
  assign chain[0] = do_sub;

  for (genvar k = 0; k < W; k++) begin : g_cell
    alu4_fa_cell u_cell (
      .bit_x (in_x[k]),
      .bit_y (y_eff[k]),
      .bit_ci(chain[k]),
      .bit_s (sum[k]),
      .bit_co(chain[k+1])
    );
  end

  assign carry_out = chain[W];
  // carries into and out of the sign cell disagree: signed overflow
  assign ovf       = chain[W] ^ chain[W-1];
endmodule

// File: rtl/alu4_logic.sv
module alu4_logic
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  output logic [W-1:0] out_l
);
  always_comb begin
    unique case (op)
      OP_NOTA: out_l = ~in_x;
      OP_AND:  out_l = in_x & in_y;
      OP_OR:   out_l = in_x | in_y;
      OP_XOR:  out_l = in_x ^ in_y;
      default: out_l = '0;
    endcase
  end
endmodule

// File: rtl/alu4_core.sv
module alu4_core
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] alu_res,
  output logic         flag_c,
  output logic         flag_v,
  output logic         flag_z
);
  localparam int PAD = W - 1;

  // named internal events
  logic         sub_mode;
  logic [W-1:0] arith_sum;
  logic         arith_carry;
  logic         arith_ovf;
  logic         lt_bit;
  logic         eq_bit;
  logic [W-1:0] logic_out;

  assign sub_mode = needs_sub(op_sel);

  alu4_addsub #(.W(W)) u_addsub (
    .in_x     (opnd_a),
    .in_y     (opnd_b),
    .do_sub   (sub_mode),
    .sum      (arith_sum),
    .carry_out(arith_carry),
    .ovf      (arith_ovf)
  );

  alu4_logic #(.W(W)) u_logic (
    .op   (op_sel),
    .in_x (opnd_a),
    .in_y (opnd_b),
    .out_l(logic_out)
  );

  // comparisons read the shared difference
  assign lt_bit = arith_sum[W-1] ^ arith_ovf;
  assign eq_bit = ~(|arith_sum);

  always_comb begin
    unique case (op_sel)
      OP_ADD, OP_SUB: alu_res = arith_sum;
      OP_SLT:         alu_res = {{PAD{1'b0}}, lt_bit};
      OP_EQ:          alu_res = {{PAD{1'b0}}, eq_bit};
      default:        alu_res = logic_out;
    endcase
  end

  assign flag_c = is_arith(op_sel) & arith_carry;
  assign flag_v = is_arith(op_sel) & arith_ovf;
  assign flag_z = ~(|alu_res);
endmodule

// File: rtl/alu4_core_chk.sv
module alu4_core_chk (
  input logic [2:0] op_sel,
  input logic [3:0] opnd_a,
  input logic [3:0] opnd_b,
  input logic [3:0] alu_res,
  input logic       flag_c,
  input logic       flag_v,
  input logic       flag_z
);
  logic [4:0] wide_sum;
  int         sdiff;
  int         ssum;

  always_comb begin
    wide_sum = {1'b0, opnd_a} + {1'b0, opnd_b};
    ssum     = int'($signed(opnd_a)) + int'($signed(opnd_b));
    sdiff    = int'($signed(opnd_a)) - int'($signed(opnd_b));

    if (op_sel == 3'b000) begin
      AST_ADD_SUM: assert ({flag_c, alu_res} == wide_sum) else $error("add sum/carry"); // R1
      AST_ADD_OVF: assert (flag_v == (ssum > 7 || ssum < -8)) else $error("add ovf"); // R3
    end
    if (op_sel == 3'b001) begin
      AST_SUB_OVF: assert (flag_v == (sdiff > 7 || sdiff < -8)) else $error("sub ovf"); // R4
      AST_SUB_BORROW: assert (flag_c == (opnd_a >= opnd_b)) else $error("sub carry"); // R4
    end
    if (op_sel[2] | op_sel[1]) begin
      AST_NO_ARITH_FLAGS: assert (!flag_c && !flag_v) else $error("flags not quiet"); // R9
    end
    if (op_sel == 3'b110) begin
      AST_SLT_VAL: assert (alu_res == {3'b000, ($signed(opnd_a) < $signed(opnd_b))}) else $error("slt"); // R7
    end
    if (op_sel == 3'b111) begin
      AST_EQ_VAL: assert (alu_res == {3'b000, (opnd_a == opnd_b)}) else $error("eq"); // R8
      AST_EQ_ZERO: assert (flag_z == (opnd_a != opnd_b)) else $error("eq zero flag"); // R10
    end
  end
endmodule

bind alu4_core alu4_core_chk u_chk (
  .op_sel (op_sel),
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .alu_res(alu_res),
  .flag_c (flag_c),
  .flag_v (flag_v),
  .flag_z (flag_z)
);

// File: tb/tb_alu4_core.sv
`timescale 1ns/1ps
module tb_alu4_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_sel = 3'b000;
  logic [3:0] opnd_a = 4'h0;
  logic [3:0] opnd_b = 4'h0;
  logic [3:0] alu_res;
  logic       flag_c, flag_v, flag_z;

  int n_chk  = 0;
  int n_fail = 0;
  bit driver_done = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [2:0] op;
    logic [3:0] a;
    logic [3:0] b;
    logic [3:0] res;
    logic       c;
    logic       v;
    logic       z;
  } exp_t;

  exp_t sb_q[$];

  always #5 clk = ~clk;

  alu4_core dut (
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .alu_res(alu_res),
    .flag_c (flag_c),
    .flag_v (flag_v),
    .flag_z (flag_z)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual=%0d expected=%0d",
               tag, op_sel, opnd_a, opnd_b, act, expv);
    end
  endtask

  function automatic string res_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R5";
      3'd6: return "R7";
      3'd7: return "R8";
      default: return "R6";
    endcase
  endfunction

  // reference model written from the requirements
  task automatic drive(input int op, input int ia, input int ib);
    exp_t e;
    int   r;
    int   ua, ub;
    ua = ia & 15;
    ub = ib & 15;
    e.c = 1'b0;
    e.v = 1'b0;
    case (op)
      0: begin r = ia + ib; e.c = (ua + ub) > 15; e.v = (r > 7) || (r < -8); end
      1: begin r = ia - ib; e.c = (ua >= ub);     e.v = (r > 7) || (r < -8); end
      2: r = ~ia;
      3: r = ia & ib;
      4: r = ia | ib;
      5: r = ia ^ ib;
      6: r = (ia < ib) ? 1 : 0;
      default: r = (ia == ib) ? 1 : 0;
    endcase
    e.op  = op[2:0];
    e.a   = ua[3:0];
    e.b   = ub[3:0];
    e.res = r[3:0];
    e.z   = (r[3:0] == 4'h0);
    @(posedge clk);
    op_sel = e.op;
    opnd_a = e.a;
    opnd_b = e.b;
    sb_q.push_back(e);
  endtask

  // monitor: compare half a period after each drive
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check(alu_res == e.res, res_tag(e.op), alu_res, e.res);
        check(flag_c == e.c, (e.op == 3'd0) ? "R3" : (e.op == 3'd1) ? "R4" : "R9", flag_c, e.c);
        check(flag_v == e.v, (e.op == 3'd0) ? "R3" : (e.op == 3'd1) ? "R4" : "R9", flag_v, e.v);
        check(flag_z == e.z, "R10", flag_z, e.z);
      end
      if (driver_done && sb_q.size() == 0 && !finished) begin
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state: 0 + 0 gives zero result with zero flag set (R10)
    check(alu_res == 4'h0, "R1", alu_res, 0);
    check(flag_z == 1'b1, "R10", flag_z, 1);
    // R5: B has no effect on NOT A
    drive(2, 5, -8);
    drive(2, 5, 7);
    // R4: most negative subtrahend
    drive(1, 0, -8);
    drive(1, -1, -8);
    // full sweep: every opcode and operand pair (R1..R10)
    for (int op = 0; op < 8; op++)
      for (int signed ia = -8; ia <= 7; ia++)
        for (int signed ib = -8; ib <= 7; ib++)
          drive(op, ia, ib);
    driver_done = 1'b1;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule